// File: doc/BRIEF.md
# Histogram-Based Byte Sorter

This block sorts a short burst of unsigned bytes without ever comparing two of them. It keeps one occurrence counter per possible byte value in a small synchronous-read memory. While a burst arrives, one item per clock, each item adds one to the counter addressed by its value. After the item flagged as final, the block walks the counters from value 0 upward. It presents each value on its output once for every time that value arrived, and marks the final output beat.

The input side is a ready/valid port. The block lowers its ready from the end of a burst until the sorted burst has been fully emitted. The output side is a plain valid stream with no backpressure. Each counter is zeroed in the cycle it is read, so the next burst starts on a clean histogram. A sweep after reset zeroes the memory before the first burst.

Each counter update is a read-modify-write. Identical values on consecutive cycles are handled by forwarding the freshly written count to the next update. A value that never arrived costs exactly one scan cycle. The scan stops as soon as the last item has been emitted.

Top module: `csort_engine`

## Requirements
- R1: After reset, inReady stays low while the histogram is zeroed, one counter per cycle (2^DATA_W cycles), and then rises. The first burst sorts correctly with no prior writes.
- R2: An item is taken on a clock edge where inValid and inReady are both high. inLast marks the final item of a burst. Idle cycles between items of a burst are allowed.
- R3: The output beats of a burst carry exactly the multiset of input values, in non-decreasing order.
- R4: Repeated values, including identical values on back-to-back cycles, are each counted once, with no update lost.
- R5: A burst of N items yields exactly N output beats. outLast is high on the Nth beat and on no other.
- R6: inReady is low from the acceptance of the final item until the cycle after outLast. Items offered in that window have no effect on any output, and no output beat is ever produced while inReady is high.
- R7: For a burst delivered on consecutive cycles, the final output beat appears no more than 256 + 2N clock edges after the edge that accepts the first item (DATA_W = 8).
- R8: Every counter read during the scan is left at zero, so consecutive bursts are independent.
- R9: Up to MAX_ITEMS (48) copies of one value in a burst are counted and emitted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input item present |
| inData | input | DATA_W | Input item value |
| inLast | input | 1 | Input item is the last of the burst |
| inReady | output | 1 | Block accepts an item this cycle |
| outValid | output | 1 | Output beat present |
| outData | output | DATA_W | Output beat value |
| outLast | output | 1 | Output beat is the last of the burst |

## Verification
The sorter is exercised with several kinds of burst:
- A short mixed burst with duplicates and both extreme values (0 and 255) checks ordering and the edge bins.
- Runs of identical values on consecutive cycles separate a working count forward from a lost update.
- A full burst of 48 copies of the top value checks counter capacity and the longest scan.
- A single item of value 0 checks the case where the only count is forwarded into the first scanned bin.
- A pseudo-random burst with idle gaps, a strictly descending burst, and bursts run back to back check general ordering and that the histogram is left clear between bursts.

Throughout, junk items are offered while the block is busy, to show they are ignored.

// File: rtl/csort_pkg.sv
package csort_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_SCAN  = 2'd3
  } csort_state_e;

  typedef struct packed {
    logic clear;
    logic accept;
    logic drain;
    logic scan;
  } csort_ctl_t;

endpackage

// File: rtl/csort_hist_ram.sv
module csort_hist_ram #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/csort_ctrl.sv
module csort_ctrl
  import csort_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       clearDone,
  input  logic       finalBeat,
  output logic       inReady,
  output csort_ctl_t ctl
);
  csort_state_e state, stateNext;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    inReady    = 1'b0;
    case (state)
      ST_CLEAR: begin
        ctl.clear = 1'b1;
        if (clearDone) stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        inReady    = 1'b1;
        ctl.accept = inValid;
        if (inValid && inLast) stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        ctl.drain = 1'b1;
        stateNext = ST_SCAN;
      end
      default: begin
        ctl.scan = 1'b1;
        if (finalBeat) stateNext = ST_LOAD;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_CLEAR;
    else        state <= stateNext;
  end

  // R6
  last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finalBeat |=> inReady);

  // R6
  drain_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inLast && inReady) |=> !inReady);
endmodule

// File: rtl/csort_datapath.sv
module csort_datapath
  import csort_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_ITEMS = 48,
  parameter int CNT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csort_ctl_t        ctl,
  input  logic [DATA_W-1:0] inData,
  output logic              clearDone,
  output logic              finalBeat,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast
);
  logic              s1Valid;
  logic [DATA_W-1:0] s1Addr;
  logic              fwdValid;
  logic [DATA_W-1:0] fwdAddr;
  logic [CNT_W-1:0]  fwdData;
  logic [CNT_W-1:0]  rdData, effCnt, incData;
  logic [DATA_W-1:0] curBin;
  logic              fresh;
  logic [CNT_W-1:0]  remReg, scanCnt;
  logic [CNT_W-1:0]  itemCnt;
  logic              emit, advance;
  logic              wrEn;
  logic [DATA_W-1:0] wrAddr, rdAddr;
  logic [CNT_W-1:0]  wrData;

  csort_hist_ram #(.ADDR_W(DATA_W), .WORD_W(CNT_W)) u_ram (
    .clk    (clk),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  // count update: forward the value written last cycle when addresses match
  always_comb begin
    effCnt  = (fwdValid && fwdAddr == s1Addr) ? fwdData : rdData;
    incData = effCnt + 1'b1;
  end

  // scan: first look at a bin takes the memory (or forwarded) count
  always_comb begin
    if (fresh) scanCnt = (fwdValid && fwdAddr == curBin) ? fwdData : rdData;
    else       scanCnt = remReg;
    emit    = ctl.scan && (scanCnt != '0);
    advance = ctl.scan && (scanCnt <= CNT_W'(1));
  end

  always_comb begin
    wrEn   = 1'b0;
    wrAddr = curBin;
    wrData = '0;
    if (s1Valid) begin
      wrEn   = 1'b1;
      wrAddr = s1Addr;
      wrData = incData;
    end else if (ctl.clear) begin
      wrEn   = 1'b1;
    end else if (ctl.scan && fresh && scanCnt != '0) begin
      wrEn   = 1'b1;
    end
  end

  always_comb begin
    if (ctl.accept)     rdAddr = inData;
    else if (ctl.drain) rdAddr = '0;
    else if (advance)   rdAddr = curBin + 1'b1;
    else                rdAddr = curBin;
  end

  assign clearDone = ctl.clear && (&curBin);
  assign outValid  = emit;
  assign outData   = curBin;
  assign outLast   = emit && (itemCnt == CNT_W'(1));
  assign finalBeat = outLast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s1Addr   <= '0;
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      fwdData  <= '0;
      curBin   <= '0;
      fresh    <= 1'b0;
      remReg   <= '0;
      itemCnt  <= '0;
    end else begin
      s1Valid  <= ctl.accept;
      if (ctl.accept) s1Addr <= inData;
      fwdValid <= s1Valid;
      fwdAddr  <= s1Addr;
      fwdData  <= incData;

      if (ctl.accept)  itemCnt <= itemCnt + 1'b1;
      else if (emit)   itemCnt <= itemCnt - 1'b1;

      if (ctl.clear) begin
        curBin <= curBin + 1'b1;
      end else if (ctl.drain) begin
        curBin <= '0;
        fresh  <= 1'b1;
      end else if (ctl.scan) begin
        if (advance) begin
          curBin <= curBin + 1'b1;
          fresh  <= 1'b1;
        end else begin
          fresh  <= 1'b0;
          remReg <= scanCnt - 1'b1;
        end
      end
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1Valid |-> effCnt < CNT_W'(MAX_ITEMS));

  // R3
  asc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(outValid)) |-> outData >= $past(outData));

  // R5
  drain_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.drain |-> itemCnt != '0);
endmodule

// File: rtl/csort_engine.sv
module csort_engine
  import csort_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_ITEMS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast
);
  localparam int CNT_W = $clog2(MAX_ITEMS + 1);

  csort_ctl_t ctl;
  logic       clearDone, finalBeat;

  csort_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .inLast    (inLast),
    .clearDone (clearDone),
    .finalBeat (finalBeat),
    .inReady   (inReady),
    .ctl       (ctl)
  );

  csort_datapath #(.DATA_W(DATA_W), .MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .inData    (inData),
    .clearDone (clearDone),
    .finalBeat (finalBeat),
    .outValid  (outValid),
    .outData   (outData),
    .outLast   (outLast)
  );

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);
endmodule

// File: tb/csort_engine_tb.sv
module csort_engine_tb;
  localparam int DW   = 8;
  localparam int MAXN = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inLast = 1'b0;
  logic          inReady, outValid, outLast;
  logic [DW-1:0] outData;

  always #5 clk = ~clk;

  csort_engine #(.DATA_W(DW), .MAX_ITEMS(MAXN)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int firstCyc = 0;
  int lastElapsed = 0;
  int expQ[$];
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      chk(!inReady, "R6", "inReady during output beat", int'(inReady), 0);
      if (expQ.size() == 0) begin
        chk(1'b0, "R6", "unexpected output beat", int'(outData), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        chk(int'(outData) == e, "R3", "output value", int'(outData), e);
        chk(outLast == (expQ.size() == 0), "R5", "outLast flag",
            int'(outLast), int'(expQ.size() == 0));
      end
      if (outLast) lastElapsed = cyc - firstCyc - 1;
    end
  end

  task automatic sendSet(input int items[$], input int gap, input bit timed,
                         input string req);
    int srt[$];
    srt = items;
    srt.sort();
    @(negedge clk);
    foreach (items[i]) begin
      if (i > 0) begin
        @(negedge clk);
        if (gap > 0) begin
          inValid = 1'b0;
          repeat (gap) @(negedge clk);
        end
      end
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inData  = DW'(items[i]);
      inLast  = (i == items.size() - 1);
      if (i == 0) firstCyc = cyc;
    end
    foreach (srt[j]) expQ.push_back(srt[j]);
    @(negedge clk);
    // offer junk while busy: must be ignored (R6)
    while (!inReady) begin
      inValid = 1'b1;
      inData  = 8'hA5;
      inLast  = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    chk(expQ.size() == 0, "R5", {req, " beats missing"}, expQ.size(), 0);
    if (timed)
      chk(lastElapsed <= 256 + 2 * items.size(), "R7", "cycles to last beat",
          lastElapsed, 256 + 2 * items.size());
  endtask

  initial begin
    int q[$];
    int n;
    int s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!inReady, "R1", "inReady during clear sweep", int'(inReady), 0);
    chk(!outValid, "R1", "outValid after reset", int'(outValid), 0);
    n = 1;
    while (!inReady && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 250 && n <= 260, "R1", "clear sweep length", n, 256);

    // R2 R3: mixed burst with edge values
    q = '{5, 3, 200, 3, 0, 255, 17};
    sendSet(q, 0, 1'b1, "R3");

    // R4: back-to-back equal values
    q = '{9, 9, 9, 9, 2, 2, 9};
    sendSet(q, 0, 1'b1, "R4");

    // R9: full burst of one top value (longest scan)
    q = {};
    for (int k = 0; k < MAXN; k++) q.push_back(255);
    sendSet(q, 0, 1'b1, "R9");

    // single item in bin 0 (forwarded into first scanned bin)
    q = '{0};
    sendSet(q, 0, 1'b1, "R5");

    // R2 R8: pseudo-random full burst with idle gaps
    q = {};
    s = 32'h1234;
    for (int k = 0; k < MAXN; k++) begin
      s = s * 1103515245 + 12345;
      q.push_back((s >>> 16) & 255);
    end
    sendSet(q, 2, 1'b0, "R8");

    // R8: descending burst right after
    q = {};
    for (int k = 0; k < MAXN; k++) q.push_back(240 - 5 * k);
    sendSet(q, 0, 1'b1, "R8");

    // R4: alternating repeats with one-cycle gaps
    q = '{7, 7, 1, 7, 1, 1, 128, 128};
    sendSet(q, 1, 1'b0, "R4");

    repeat (5) @(negedge clk);
    chk(!outValid, "R6", "idle after last burst", int'(outValid), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule